// File: doc/BRIEF.md
# Configurable Synchronous Burst SRAM

This block is a synthesizable single-data-rate synchronous SRAM with a small parameterized array. Its common data bus is split into a read port, a write port and an output-enable flag. The clock's rising edge samples the address, the write data and every control input, and that same edge starts a write. No separate write strobe is needed.

A static strap selects the read path. In flow-through mode the array drives the output in the cycle that follows the sampling edge. In pipeline mode an output register holds the data for one more cycle. In that mode, deselection takes two cycles, and a complementary pair of echo outputs marks each cycle in which data is driven.

The device is selected only when all three chip enables are asserted. One enable is fixed active-low. The other two each have a polarity strap. An advance input continues the current burst through a 4-beat block that wraps. Writes are posted in a one-entry buffer and reach the array when the next write arrives. A read that hits the buffer returns the posted bytes.

Top module: `sync_burst_sram`

## Requirements
- R1: An access is accepted only when ce1_ni is 0 and both programmable enables are asserted; any other combination on a non-advance cycle leaves the array unchanged and starts no read.
- R2: ce2_pol_i and ce3_pol_i set the active level of ce2_i and ce3_i respectively (1 = active high, 0 = active low).
- R3: A selected cycle with we_ni = 0 stores wdata_i byte k (bits 9k+8 down to 9k) only where bw_ni[k] = 0; other bytes of the word keep their value.
- R4: With flow_mode_i = 1, a read sampled at edge t drives oe_o = 1 and the word on rdata_o from edge t until edge t+1.
- R5: With flow_mode_i = 0, a read sampled at edge t drives oe_o = 1 and the word on rdata_o from edge t+1 until edge t+2.
- R6: In pipeline mode, a deselecting or idle cycle that follows a read leaves the output driven for one more cycle; oe_o then falls.
- R7: When adv_i = 1 after an active cycle, the access continues in the same direction at the next address: the two lowest bits increment modulo 4 and the upper bits stay fixed. The chip enables and we_ni are ignored; bw_ni and wdata_i apply per beat.
- R8: When adv_i = 1 after an idle or deselected cycle, nothing is read or written.
- R9: A read of an address whose write is still posted returns the newly written bytes merged over the older array contents.
- R10: echo_no is always the complement of echo_o. In pipeline mode echo_o toggles at each edge that begins a driven output cycle. In flow-through mode echo_o holds its value.
- R11: After reset, oe_o = 0, rdata_o = 0, echo_o = 0, no burst is active and no write is pending.
- R12: rdata_o is all zeros whenever oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_mode_i | input | 1 | Read path strap: 1 flow-through, 0 pipeline |
| ce2_pol_i | input | 1 | Active level of ce2_i |
| ce3_pol_i | input | 1 | Active level of ce3_i |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, programmable level |
| ce3_i | input | 1 | Chip enable, programmable level |
| adv_i | input | 1 | Continue burst, active high |
| we_ni | input | 1 | Write command, active low |
| bw_ni | input | BYTES | Byte write enables, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 9*BYTES | Write data |
| rdata_o | output | 9*BYTES | Read data, zero when not driven |
| oe_o | output | 1 | Output driven |
| echo_o | output | 1 | Echo marker, true |
| echo_no | output | 1 | Echo marker, complement |

## Verification
A wrong burst counter makes the beat after the fault read the wrong word, and this shows on rdata_o one cycle later in flow-through mode and two cycles later in pipeline mode. A lost or stale posted write shows at the first read of that address. That read may come right after the write, through the bypass, or after the next write, once the buffer has retired into the array. A stuck pipeline flag shows as oe_o or echo_o being wrong in the cycle after a read or after a deselect. Each address is written and then read back under every read mode and every enable polarity, so such faults surface within a few cycles of their cause.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BYTE_W = 9;
  typedef enum logic {RD_PIPE = 1'b0, RD_FLOW = 1'b1} rd_mode_e;
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce2_pol_i,
  input  logic              ce3_pol_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_go_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_act_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic              sel;
  logic              act_q, wr_q, nxt_act, nxt_wr;
  logic [ADDR_W-1:0] addr_q, nxt_addr;

  assign sel = ~ce1_ni & (ce2_i ~^ ce2_pol_i) & (ce3_i ~^ ce3_pol_i);

  always_comb begin
    nxt_act  = 1'b0;
    nxt_wr   = wr_q;
    nxt_addr = addr_q;
    if (adv_i) begin
      if (act_q) begin
        nxt_act  = 1'b1;
        nxt_addr = {addr_q[ADDR_W-1:BURST_W], addr_q[BURST_W-1:0] + BURST_W'(1)};
      end
    end else if (sel) begin
      nxt_act  = 1'b1;
      nxt_wr   = ~we_ni;
      nxt_addr = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q  <= nxt_act;
      wr_q   <= nxt_wr;
      addr_q <= nxt_addr;
    end
  end

  assign wr_go_o    = nxt_act & nxt_wr;
  assign wr_addr_o  = nxt_addr;
  assign rd_act_o   = act_q & ~wr_q;
  assign acc_addr_o = addr_q;

  p_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && ce1_ni) |=> (!rd_act_o && !act_q));
  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && act_q) |=> (acc_addr_o[BURST_W-1:0] == BURST_W'($past(acc_addr_o[BURST_W-1:0]) + 1'b1)));
  p_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && act_q) |=> (acc_addr_o[ADDR_W-1:BURST_W] == $past(acc_addr_o[ADDR_W-1:BURST_W])));
  p_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !act_q) |=> !act_q);
endmodule

// File: rtl/sram_wbuf_array.sv
module sram_wbuf_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  localparam int BW     = sram_pkg::BYTE_W,
  localparam int DATA_W = BYTES * BW,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_go_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTES-1:0]  bw_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [BYTES-1:0]  pend_mask_q;
  logic              hit;
  logic [DATA_W-1:0] arr_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_mask_q <= '0;
    end else if (wr_go_i) begin
      pend_vld_q  <= 1'b1;
      pend_addr_q <= wr_addr_i;
      pend_data_q <= wdata_i;
      pend_mask_q <= ~bw_ni;
    end
  end

  // posted write retires when the next write is accepted
  always_ff @(posedge clk_i) begin
    if (wr_go_i && pend_vld_q) begin
      for (int k = 0; k < BYTES; k++) begin
        if (pend_mask_q[k]) mem[pend_addr_q][k*BW +: BW] <= pend_data_q[k*BW +: BW];
      end
    end
  end

  assign arr_word = mem[rd_addr_i];
  assign hit      = pend_vld_q && (pend_addr_q == rd_addr_i);

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign rd_word_o[k*BW +: BW] = (hit && pend_mask_q[k]) ? pend_data_q[k*BW +: BW]
                                                            : arr_word[k*BW +: BW];
  end

  p_post_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_i |=> (pend_vld_q && pend_addr_q == $past(wr_addr_i)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_go_i |=> $stable(pend_data_q));
endmodule

// File: rtl/sram_read_out.sv
module sram_read_out #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flow_i,
  input  logic              rd_act_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic              echo_o,
  output logic              echo_no
);
  import sram_pkg::*;
  rd_mode_e          mode;
  logic              rd_q, echo_q;
  logic [DATA_W-1:0] dat_q;

  assign mode = flow_i ? RD_FLOW : RD_PIPE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      dat_q  <= '0;
      echo_q <= 1'b0;
    end else begin
      rd_q   <= rd_act_i;
      dat_q  <= rd_act_i ? rd_word_i : '0;
      echo_q <= echo_q ^ ((mode == RD_PIPE) & rd_act_i);
    end
  end

  assign oe_o    = (mode == RD_FLOW) ? rd_act_i : rd_q;
  assign rdata_o = !oe_o ? '0 : ((mode == RD_FLOW) ? rd_word_i : dat_q);
  assign echo_o  = echo_q;
  assign echo_no = ~echo_q;

  p_pipe_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_i && rd_act_i) |=> oe_o);
  p_pipe_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_i && !rd_act_i) |=> !oe_o);
  p_echo_flow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flow_i |=> $stable(echo_o));
  p_echo_pipe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_i && rd_act_i) |=> (echo_o != $past(echo_o)));
  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W  = 8,
  parameter int BYTES   = 2,
  parameter int BURST_W = 2,
  localparam int DATA_W = BYTES * sram_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flow_mode_i,
  input  logic              ce2_pol_i,
  input  logic              ce3_pol_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [BYTES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic              echo_o,
  output logic              echo_no
);
  logic              wr_go, rd_act;
  logic [ADDR_W-1:0] wr_addr, acc_addr;
  logic [DATA_W-1:0] rd_word;

  sram_burst_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk_i, .rst_ni, .ce2_pol_i, .ce3_pol_i, .ce1_ni, .ce2_i, .ce3_i,
    .adv_i, .we_ni, .addr_i,
    .wr_go_o(wr_go), .wr_addr_o(wr_addr), .rd_act_o(rd_act), .acc_addr_o(acc_addr)
  );

  sram_wbuf_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_arr (
    .clk_i, .rst_ni, .wr_go_i(wr_go), .wr_addr_i(wr_addr), .bw_ni,
    .wdata_i, .rd_addr_i(acc_addr), .rd_word_o(rd_word)
  );

  sram_read_out #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni, .flow_i(flow_mode_i), .rd_act_i(rd_act), .rd_word_i(rd_word),
    .rdata_o, .oe_o, .echo_o, .echo_no
  );
endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int AW = 8, NB = 2, DW = 18, DEPTH = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic flow = 1'b0, p2 = 1'b1, p3 = 1'b1;
  logic c1 = 1'b1, c2 = 1'b0, c3 = 1'b0, adv = 1'b0, we = 1'b1;
  logic [NB-1:0] bw = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0, rdata;
  logic oe, echo, echo_n;

  sync_burst_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .flow_mode_i(flow), .ce2_pol_i(p2), .ce3_pol_i(p3),
    .ce1_ni(c1), .ce2_i(c2), .ce3_i(c3), .adv_i(adv), .we_ni(we), .bw_ni(bw),
    .addr_i(addr), .wdata_i(wdat), .rdata_o(rdata), .oe_o(oe), .echo_o(echo), .echo_no(echo_n)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic m_act = 0, m_wr = 0, last_rd = 0, exp_echo = 0, exp_oe = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] last_val = '0, exp_dat = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic a_adv, input logic a_c1, input logic a_c2, input logic a_c3,
                      input logic a_we, input logic [NB-1:0] a_bw, input logic [AW-1:0] a_addr,
                      input logic [DW-1:0] a_d, input string tag);
    logic sel, rd_now, wr_now;
    logic [DW-1:0] val;
    adv = a_adv; c1 = a_c1; c2 = a_c2; c3 = a_c3; we = a_we; bw = a_bw; addr = a_addr; wdat = a_d;
    @(posedge clk);
    sel = !a_c1 && (a_c2 == p2) && (a_c3 == p3);
    rd_now = 0; wr_now = 0;
    if (a_adv) begin
      if (m_act) begin
        m_addr[1:0] = m_addr[1:0] + 2'd1;  // R7 wrap within 4-beat block
        rd_now = !m_wr; wr_now = m_wr;
      end
    end else if (sel) begin
      m_act = 1; m_wr = !a_we; m_addr = a_addr; rd_now = a_we; wr_now = !a_we;
    end else m_act = 0;
    if (wr_now)
      for (int k = 0; k < NB; k++)
        if (!a_bw[k]) ref_mem[m_addr][k*9 +: 9] = a_d[k*9 +: 9];
    val = rd_now ? ref_mem[m_addr] : '0;
    if (flow) begin exp_oe = rd_now; exp_dat = val; end
    else begin exp_oe = last_rd; exp_dat = last_val; end
    exp_echo = exp_echo ^ (!flow && last_rd);
    last_rd = rd_now; last_val = val;
    @(negedge clk);
    chk(tag, {17'd0, oe}, {17'd0, exp_oe});
    chk(exp_oe ? tag : "R12", rdata, exp_dat);
    chk("R10", {17'd0, echo}, {17'd0, exp_echo});
    chk("R10", {17'd0, echo_n}, {17'd0, ~exp_echo});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] m, input string tag);
    step(0, 0, p2, p3, 0, m, a, d, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(0, 0, p2, p3, 1, '1, a, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 1, p2, p3, 1, '1, '0, '0, tag);
  endtask
  // advance beat with enables deasserted and we_ni flipped: they must be ignored (R7)
  task automatic beat(input logic wdir, input logic [NB-1:0] m, input logic [DW-1:0] d, input string tag);
    step(1, 1, ~p2, ~p3, wdir, m, '0, d, tag);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int cfg);
    return DW'((a * 1237 + cfg * 4099 + 77) ^ (a << 9));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", {17'd0, oe}, '0);
    chk("R11", rdata, '0);
    chk("R11", {17'd0, echo}, '0);
    chk("R11", {17'd0, echo_n}, 18'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int cfg = 0; cfg < 8; cfg++) begin
      string rt;
      flow = cfg[2]; p2 = cfg[0]; p3 = cfg[1];
      rt = flow ? "R4" : "R5";
      idle("R6"); idle("R6");
      // full sweep of writes under this polarity (R2, R3)
      for (int a = 0; a < DEPTH; a++) wr(AW'(a), pat(a, cfg), '0, "R2");
      // burst reads from varying start offsets, wrapping in the block (R7)
      for (int b = 0; b < DEPTH; b += 4) begin
        rd(AW'(b + ((b >> 2) & 3)), rt);
        beat(0, '1, '0, "R7"); beat(0, '1, '0, "R7"); beat(0, '1, '0, "R7");
      end
      idle("R6"); idle("R6"); idle("R6");
      // pipeline deselect after a single read
      rd(8'h11, rt); idle("R6"); idle("R6");
      rd(8'h12, rt); step(0, 0, ~p2, p3, 1, '1, 8'h13, '0, "R6"); idle("R6");
      // partial byte writes, immediate readback through the posted buffer (R3, R9)
      wr(8'h05, 18'h2a5a5, 2'b10, "R3"); rd(8'h05, "R9");
      wr(8'h05, 18'h15c3c, 2'b01, "R3"); rd(8'h05, "R9");
      wr(8'h06, 18'h3ffff, 2'b11, "R3"); rd(8'h05, "R3"); rd(8'h06, "R3");
      wr(8'h07, 18'h0f0f0, 2'b00, "R9"); wr(8'h07, 18'h30303, 2'b10, "R9"); rd(8'h07, "R9");
      // deselected writes leave the array unchanged (R1, R2)
      step(0, 1, p2, p3, 0, '0, 8'h09, 18'h1dead, "R1");
      step(0, 0, ~p2, p3, 0, '0, 8'h09, 18'h1beef, "R2");
      step(0, 0, p2, ~p3, 0, '0, 8'h09, 18'h10f0f, "R2");
      step(0, 0, ~p2, ~p3, 1, '1, 8'h09, '0, "R1");
      rd(8'h09, "R1"); idle("R1");
      // advance after idle is a no-op (R8)
      idle("R8"); step(1, 0, p2, p3, 0, '0, 8'h0a, 18'h3aaaa, "R8");
      step(1, 0, p2, p3, 1, '1, 8'h0a, '0, "R8");
      rd(8'h0a, "R8"); idle("R8");
      // burst write with wrap, mixed byte masks, then burst readback (R7)
      wr(8'h43, 18'h11111, '0, "R7");
      beat(1, 2'b00, 18'h22222, "R7");
      beat(1, 2'b01, 18'h33333, "R7");
      beat(1, 2'b10, 18'h04444, "R7");
      rd(8'h40, "R7");
      beat(0, '1, '0, "R7"); beat(0, '1, '0, "R7"); beat(0, '1, '0, "R7"); beat(0, '1, '0, "R7");
      idle("R6"); idle("R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule